// File: doc/BRIEF.md
# Variable-Page Translation Buffer with Access Checking

This block is a fully associative translation buffer with sixteen entries. It turns a 32-bit effective address into a 36-bit real address. Each entry describes one page. A page can be 4 KB, 16 KB, 64 KB and so on, growing by a factor of four up to 4 GB. Each entry also carries an address-space bit, a translation ID, six access-permission bits and attribute bits that travel with the translation.

A lookup is presented for one cycle together with the current address space, three process IDs, the privilege mode and the kind of access. One cycle later the block returns hit or miss, the real address, the attributes, a permission fault and a flag that reports when more than one entry matched. Software loads and inspects entries one at a time through a staging port. A flash-invalidate input clears every entry that is not protected.

Top module: `vp_tlb`

## Requirements
- R1: An entry can match only when its valid bit is 1 and its address-space bit equals `lk_as_i`.
- R2: An entry can match only when its translation ID equals `pid0_i`, `pid1_i` or `pid2_i`. An entry whose translation ID is 8'h00 matches any process.
- R3: Size code s selects a page of 4 KB × 4^(s-1) for s = 1 to 11. The lowest 2·(s-1) bits of the effective page number are left out of the compare against `lk_ea_i[31:12]`. Codes 0 and 12 to 15 never match.
- R4: On a hit, let off = 12 + 2·(s-1). `ra_o` is {rpn, 12'h000} with its low off bits replaced by the same bits of `lk_ea_i`.
- R5: The permission field is perm[5:0] = {sup-exec, sup-write, sup-read, user-exec, user-write, user-read}. `lk_sup_i`=1 selects the upper three bits. `lk_acc_i` 2 (fetch) selects exec, 1 (store) selects write, and 0 or 3 (load) selects read. `fault_o` is 1 on a hit whose selected bit is 0.
- R6: The guarded attribute, `wimge` bit 1, has no effect on `fault_o` for any access, fetches included.
- R7: On a miss or an idle cycle, `hit_o`, `fault_o`, `multi_o`, `ra_o` and all attribute outputs are 0.
- R8: When several entries match, the lowest-index entry supplies the result and `multi_o` is 1. `multi_o` is 0 when exactly one entry matches.
- R9: A 1 on `flash_inv_i` clears the valid bit of every entry whose invalidate-protect bit is 0 and leaves every other field unchanged. Protected entries are not affected. A staging write in the same cycle wins for its own index.
- R10: The staging word is {valid[75], as[74], tid[73:66], epn[65:46], rpn[45:22], size[21:18], perm[17:12], wimge[11:7], xattr[6:5], uattr[4:1], iprot[0]}. `stg_wr_i` stores the word at `stg_idx_i`. `stg_rd_i` places that entry on `stg_rdata_o` one cycle later.
- R11: The results of a lookup accepted with `lk_valid_i` appear one cycle later, with `rvld_o` set to 1.
- R12: On a hit, `wimge_o`, `xattr_o` and `uattr_o` equal the stored fields of the selected entry.
- R13: After reset, every entry reads as all zeros and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_ea_i | input | 32 | Effective address |
| lk_as_i | input | 1 | Current address space |
| pid0_i | input | 8 | Process ID 0 |
| pid1_i | input | 8 | Process ID 1 |
| pid2_i | input | 8 | Process ID 2 |
| lk_sup_i | input | 1 | 1 = supervisor mode |
| lk_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rvld_o | output | 1 | Result valid |
| hit_o | output | 1 | Translation hit |
| multi_o | output | 1 | More than one entry matched |
| fault_o | output | 1 | Permission fault |
| ra_o | output | 36 | Real address |
| wimge_o | output | 5 | Cache attributes |
| xattr_o | output | 2 | System attribute bits |
| uattr_o | output | 4 | Software attribute bits |
| stg_idx_i | input | 4 | Staging entry index |
| stg_wr_i | input | 1 | Write the staging word to an entry |
| stg_rd_i | input | 1 | Read an entry into the staging word |
| stg_wdata_i | input | 76 | Staging write word |
| stg_rdata_o | output | 76 | Staging read word |
| flash_inv_i | input | 1 | Invalidate unprotected entries |

## Verification
The assertions assume that `lk_valid_i` is a clean, known level at every clock edge. The offset check also assumes that a page is never smaller than 4 KB, which holds because size codes below 1 never match. The bench keeps to these assumptions: it changes inputs only on falling edges and holds `lk_valid_i` for exactly one cycle per lookup. It also leaves the staging port idle while it sweeps lookups, so the table cannot change underneath a compare. Multiple matches occur only in the test that sets them up on purpose.

// File: rtl/vp_tlb_pkg.sv
package vp_tlb_pkg;
  localparam int EA_W     = 32;
  localparam int RA_W     = 36;
  localparam int TID_W    = 8;
  localparam int EPN_W    = 20;
  localparam int RPN_W    = 24;
  localparam int SZ_W     = 4;
  localparam int PERM_W   = 6;
  localparam int WIMGE_W  = 5;
  localparam int XB_W     = 2;
  localparam int UB_W     = 4;
  localparam int PG_SHIFT = 12;
  localparam int SZ_MAX   = 11;
  localparam int ENT_W    = 2 + TID_W + EPN_W + RPN_W + SZ_W + PERM_W + WIMGE_W + XB_W + UB_W + 1;

  typedef struct packed {
    logic               valid;
    logic               as_bit;
    logic [TID_W-1:0]   tid;
    logic [EPN_W-1:0]   epn;
    logic [RPN_W-1:0]   rpn;
    logic [SZ_W-1:0]    size;
    logic [PERM_W-1:0]  perm;
    logic [WIMGE_W-1:0] wimge;
    logic [XB_W-1:0]    xattr;
    logic [UB_W-1:0]    uattr;
    logic               iprot;
  } entry_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  // number of page-number bits dropped from the compare
  function automatic logic [4:0] size_shift(input logic [SZ_W-1:0] sz);
    logic [SZ_W-1:0] m;
    m = sz - SZ_W'(1);
    return {m, 1'b0};
  endfunction
endpackage

// File: rtl/vp_tlb_match.sv
module vp_tlb_match
  import vp_tlb_pkg::*;
(
  input  entry_t            ent_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic              as_i,
  input  logic [TID_W-1:0]  pid0_i,
  input  logic [TID_W-1:0]  pid1_i,
  input  logic [TID_W-1:0]  pid2_i,
  output logic              hit_o
);
  logic [4:0]       sh;
  logic [EPN_W:0]   low_m;
  logic [EPN_W-1:0] cmp_m;
  logic             size_ok, epn_ok, tid_ok;

  always_comb begin
    sh      = size_shift(ent_i.size);
    low_m   = ((EPN_W+1)'(1) << sh) - (EPN_W+1)'(1);
    cmp_m   = ~low_m[EPN_W-1:0];
    size_ok = (ent_i.size != '0) && (ent_i.size <= SZ_W'(SZ_MAX));
    epn_ok  = ((ea_i[EA_W-1 -: EPN_W] ^ ent_i.epn) & cmp_m) == '0;
    tid_ok  = (ent_i.tid == '0) || (ent_i.tid == pid0_i) ||
              (ent_i.tid == pid1_i) || (ent_i.tid == pid2_i);
    hit_o   = ent_i.valid && (ent_i.as_bit == as_i) && size_ok && epn_ok && tid_ok;
  end
endmodule

// File: rtl/vp_tlb_prio.sv
module vp_tlb_prio #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  hit_i,
  output logic          any_o,
  output logic          multi_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_i[i]) idx_o = IW'(i);
    any_o   = |hit_i;
    multi_o = (hit_i & (hit_i - N'(1))) != '0;
  end
endmodule

// File: rtl/vp_tlb_perm.sv
module vp_tlb_perm
  import vp_tlb_pkg::*;
(
  input  logic [PERM_W-1:0] perm_i,
  input  logic              sup_i,
  input  logic [1:0]        acc_i,
  output logic              allow_o
);
  logic [2:0] grp; // {exec, write, read}

  always_comb begin
    grp = sup_i ? perm_i[5:3] : perm_i[2:0];
    case (acc_e'(acc_i))
      ACC_FETCH: allow_o = grp[2];
      ACC_STORE: allow_o = grp[1];
      default:   allow_o = grp[0];
    endcase
  end
endmodule

// File: rtl/vp_tlb.sv
module vp_tlb
  import vp_tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [EA_W-1:0]    lk_ea_i,
  input  logic               lk_as_i,
  input  logic [TID_W-1:0]   pid0_i,
  input  logic [TID_W-1:0]   pid1_i,
  input  logic [TID_W-1:0]   pid2_i,
  input  logic               lk_sup_i,
  input  logic [1:0]         lk_acc_i,
  output logic               rvld_o,
  output logic               hit_o,
  output logic               multi_o,
  output logic               fault_o,
  output logic [RA_W-1:0]    ra_o,
  output logic [WIMGE_W-1:0] wimge_o,
  output logic [XB_W-1:0]    xattr_o,
  output logic [UB_W-1:0]    uattr_o,
  input  logic [IDX_W-1:0]   stg_idx_i,
  input  logic               stg_wr_i,
  input  logic               stg_rd_i,
  input  logic [ENT_W-1:0]   stg_wdata_i,
  output logic [ENT_W-1:0]   stg_rdata_o,
  input  logic               flash_inv_i
);
  entry_t             ent_q [N_ENT];
  logic [N_ENT-1:0]   hits;
  logic               any_hit, multi_hit, allow;
  logic [IDX_W-1:0]   sel_idx;
  entry_t             sel;
  logic [5:0]         off;
  logic [RA_W-1:0]    off_m, ra_c;

  // entry storage: staging write wins over flash invalidate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (stg_wr_i && stg_idx_i == IDX_W'(i))
          ent_q[i] <= entry_t'(stg_wdata_i);
        else if (flash_inv_i && !ent_q[i].iprot)
          ent_q[i].valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stg_rdata_o <= '0;
    else if (stg_rd_i) stg_rdata_o <= ent_q[stg_idx_i];
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    vp_tlb_match u_match (
      .ent_i  (ent_q[g]),
      .ea_i   (lk_ea_i),
      .as_i   (lk_as_i),
      .pid0_i (pid0_i),
      .pid1_i (pid1_i),
      .pid2_i (pid2_i),
      .hit_o  (hits[g])
    );
  end

  vp_tlb_prio #(.N(N_ENT)) u_prio (
    .hit_i   (hits),
    .any_o   (any_hit),
    .multi_o (multi_hit),
    .idx_o   (sel_idx)
  );

  assign sel = ent_q[sel_idx];

  vp_tlb_perm u_perm (
    .perm_i  (sel.perm),
    .sup_i   (lk_sup_i),
    .acc_i   (lk_acc_i),
    .allow_o (allow)
  );

  always_comb begin
    off   = 6'(PG_SHIFT) + 6'(size_shift(sel.size));
    off_m = (RA_W'(1) << off) - RA_W'(1);
    ra_c  = ({sel.rpn, {PG_SHIFT{1'b0}}} & ~off_m) | (RA_W'(lk_ea_i) & off_m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvld_o  <= 1'b0;
      hit_o   <= 1'b0;
      multi_o <= 1'b0;
      fault_o <= 1'b0;
      ra_o    <= '0;
      wimge_o <= '0;
      xattr_o <= '0;
      uattr_o <= '0;
    end else begin
      rvld_o <= lk_valid_i;
      if (lk_valid_i && any_hit) begin
        hit_o   <= 1'b1;
        multi_o <= multi_hit;
        fault_o <= !allow;
        ra_o    <= ra_c;
        wimge_o <= sel.wimge;
        xattr_o <= sel.xattr;
        uattr_o <= sel.uattr;
      end else begin
        hit_o   <= 1'b0;
        multi_o <= 1'b0;
        fault_o <= 1'b0;
        ra_o    <= '0;
        wimge_o <= '0;
        xattr_o <= '0;
        uattr_o <= '0;
      end
    end
  end
endmodule

// File: rtl/vp_tlb_chk.sv
module vp_tlb_chk
  import vp_tlb_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lk_valid_i,
  input logic [EA_W-1:0] lk_ea_i,
  input logic            rvld_o,
  input logic            hit_o,
  input logic            multi_o,
  input logic            fault_o,
  input logic [RA_W-1:0] ra_o
);
  a_r7_fault_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_o);

  a_r8_multi_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);

  a_r11_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rvld_o);

  a_r11_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvld_o |-> !hit_o);

  a_r7_miss_ra_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> ra_o == '0);

  a_r4_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i ##1 hit_o |-> ra_o[PG_SHIFT-1:0] == $past(lk_ea_i[PG_SHIFT-1:0]));
endmodule

bind vp_tlb vp_tlb_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_valid_i (lk_valid_i),
  .lk_ea_i    (lk_ea_i),
  .rvld_o     (rvld_o),
  .hit_o      (hit_o),
  .multi_o    (multi_o),
  .fault_o    (fault_o),
  .ra_o       (ra_o)
);

// File: tb/vp_tlb_tb.sv
`timescale 1ns/1ps
module vp_tlb_tb;
  import vp_tlb_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_ea = '0;
  logic lk_as = 1'b0;
  logic [7:0] pid0 = '0, pid1 = '0, pid2 = '0;
  logic lk_sup = 1'b0;
  logic [1:0] lk_acc = '0;
  logic rvld, hit, multi, fault;
  logic [35:0] ra;
  logic [4:0] wimge;
  logic [1:0] xattr;
  logic [3:0] uattr;
  logic [3:0] stg_idx = '0;
  logic stg_wr = 1'b0, stg_rd = 1'b0, flash_inv = 1'b0;
  logic [ENT_W-1:0] stg_wdata = '0;
  logic [ENT_W-1:0] stg_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vp_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_ea_i(lk_ea), .lk_as_i(lk_as),
    .pid0_i(pid0), .pid1_i(pid1), .pid2_i(pid2),
    .lk_sup_i(lk_sup), .lk_acc_i(lk_acc),
    .rvld_o(rvld), .hit_o(hit), .multi_o(multi), .fault_o(fault), .ra_o(ra),
    .wimge_o(wimge), .xattr_o(xattr), .uattr_o(uattr),
    .stg_idx_i(stg_idx), .stg_wr_i(stg_wr), .stg_rd_i(stg_rd),
    .stg_wdata_i(stg_wdata), .stg_rdata_o(stg_rdata),
    .flash_inv_i(flash_inv)
  );

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ENT_W-1:0] mk(input logic v, input logic as_b, input logic [7:0] tid,
      input logic [19:0] epn, input logic [23:0] rpn, input logic [3:0] sz, input logic [5:0] perm,
      input logic [4:0] wi, input logic [1:0] xb, input logic [3:0] ub, input logic ip);
    entry_t e;
    e.valid = v; e.as_bit = as_b; e.tid = tid; e.epn = epn; e.rpn = rpn; e.size = sz;
    e.perm = perm; e.wimge = wi; e.xattr = xb; e.uattr = ub; e.iprot = ip;
    return e;
  endfunction

  function automatic logic [35:0] exp_ra(input logic [23:0] rpn, input int s, input logic [31:0] ea);
    logic [63:0] m;
    m = (64'd1 << (12 + 2 * (s - 1))) - 64'd1;
    return ({rpn, 12'h000} & ~m[35:0]) | ({4'h0, ea} & m[35:0]);
  endfunction

  task automatic wr_ent(input int idx, input logic [ENT_W-1:0] d);
    @(negedge clk);
    stg_idx = 4'(idx); stg_wdata = d; stg_wr = 1'b1;
    @(negedge clk);
    stg_wr = 1'b0;
  endtask

  task automatic rd_ent(input int idx, output logic [ENT_W-1:0] d);
    @(negedge clk);
    stg_idx = 4'(idx); stg_rd = 1'b1;
    @(negedge clk);
    stg_rd = 1'b0;
    d = stg_rdata;
  endtask

  task automatic lookup(input logic [31:0] ea, input logic as_b, input logic [7:0] p0,
      input logic [7:0] p1, input logic [7:0] p2, input logic sup, input logic [1:0] acc);
    @(negedge clk);
    lk_valid = 1'b1; lk_ea = ea; lk_as = as_b; pid0 = p0; pid1 = p1; pid2 = p2;
    lk_sup = sup; lk_acc = acc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [ENT_W-1:0] rd;
    logic [31:0] ea;
    logic [19:0] epn;
    logic [23:0] rpn;
    logic [63:0] m;
    int off;
    bit ok;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R13: reset state
    check("R13", "hit after reset", {127'b0, hit}, 128'd0);
    check("R13", "rvld after reset", {127'b0, rvld}, 128'd0);
    for (int i = 0; i < 16; i++) begin
      rd_ent(i, rd);
      check("R13", "entry after reset", rd, 128'd0);
    end
    lookup(32'h0000_0000, 1'b0, 8'h0, 8'h0, 8'h0, 1'b1, 2'd0);
    check("R13", "lookup after reset", {127'b0, hit}, 128'd0);
    check("R11", "rvld after lookup", {127'b0, rvld}, 128'd1);
    @(negedge clk);
    check("R11", "rvld idle", {127'b0, rvld}, 128'd0);

    // R10: staging write and read
    rd = mk(1'b1, 1'b1, 8'hC3, 20'h5_A5A5, 24'h96_0F1E, 4'd7, 6'h2D, 5'h1B, 2'h1, 4'hA, 1'b1);
    wr_ent(9, rd);
    rd_ent(9, rd);
    check("R10", "staging readback", rd,
          mk(1'b1, 1'b1, 8'hC3, 20'h5_A5A5, 24'h96_0F1E, 4'd7, 6'h2D, 5'h1B, 2'h1, 4'hA, 1'b1));
    wr_ent(9, '0);

    // R3 R4 R12: size sweep on entry 0
    epn = 20'hA_5C3F;
    rpn = 24'h9B_31E7;
    for (int s = 0; s < 16; s++) begin
      ok = (s >= 1) && (s <= 11);
      wr_ent(0, mk(1'b1, 1'b0, 8'h00, epn, rpn, 4'(s), 6'h3F, 5'h15, 2'h2, 4'h9, 1'b0));
      if (ok) begin
        off = 12 + 2 * (s - 1);
        m = (64'd1 << off) - 64'd1;
        ea = ({epn, 12'h000} & ~m[31:0]) | (32'h9E37_79B9 & m[31:0]);
      end else begin
        off = 12;
        ea = {epn, 12'h123};
      end
      lookup(ea, 1'b0, 8'h11, 8'h22, 8'h33, 1'b1, 2'd0);
      check("R3", $sformatf("hit size=%0d", s), {127'b0, hit}, {127'b0, ok});
      if (ok) begin
        check("R4", $sformatf("ra size=%0d", s), {92'b0, ra}, {92'b0, exp_ra(rpn, s, ea)});
        check("R12", "attrs", {117'b0, wimge, xattr, uattr}, {117'b0, 5'h15, 2'h2, 4'h9});
        if (off < 32) begin
          lookup(ea ^ (32'd1 << off), 1'b0, 8'h11, 8'h22, 8'h33, 1'b1, 2'd0);
          check("R3", $sformatf("miss above page size=%0d", s), {127'b0, hit}, 128'd0);
        end
      end else begin
        check("R7", "reserved ra zero", {92'b0, ra}, 128'd0);
      end
    end

    // R5 R6: permission sweep with guard bit both ways
    for (int p = 0; p < 64; p++) begin
      for (int g = 0; g < 2; g++) begin
        wr_ent(0, mk(1'b1, 1'b0, 8'h00, 20'h1_2345, 24'h00_0ABC, 4'd1, 6'(p),
                     (g != 0) ? 5'b00010 : 5'b00000, 2'h0, 4'h0, 1'b0));
        for (int sp = 0; sp < 2; sp++) begin
          for (int a = 0; a < 3; a++) begin
            logic allow;
            allow = p[sp * 3 + a];
            lookup(32'h1234_5678, 1'b0, 8'h0, 8'h0, 8'h0, 1'(sp), 2'(a == 0 ? 0 : (a == 1 ? 1 : 2)));
            if (g != 0 && a == 2)
              check("R6", $sformatf("guarded fetch p=%0h sup=%0d", p, sp), {127'b0, fault}, {127'b0, !allow});
            else
              check("R5", $sformatf("fault p=%0h sup=%0d acc=%0d", p, sp, a), {127'b0, fault}, {127'b0, !allow});
          end
        end
      end
    end
    // R5: access code 3 behaves as load
    wr_ent(0, mk(1'b1, 1'b0, 8'h00, 20'h1_2345, 24'h00_0ABC, 4'd1, 6'b000_001, 5'h0, 2'h0, 4'h0, 1'b0));
    lookup(32'h1234_5000, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, 2'd3);
    check("R5", "acc 3 as load", {126'b0, hit, fault}, {126'b0, 2'b10});

    // R2: process-ID compare
    wr_ent(0, mk(1'b1, 1'b0, 8'h5A, 20'h4_0000, 24'h12_3456, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b0));
    lookup(32'h4000_0010, 1'b0, 8'h5A, 8'h01, 8'h02, 1'b0, 2'd0);
    check("R2", "pid0 match", {127'b0, hit}, 128'd1);
    lookup(32'h4000_0010, 1'b0, 8'h01, 8'h5A, 8'h02, 1'b0, 2'd0);
    check("R2", "pid1 match", {127'b0, hit}, 128'd1);
    lookup(32'h4000_0010, 1'b0, 8'h01, 8'h02, 8'h5A, 1'b0, 2'd0);
    check("R2", "pid2 match", {127'b0, hit}, 128'd1);
    lookup(32'h4000_0010, 1'b0, 8'h01, 8'h02, 8'h03, 1'b0, 2'd0);
    check("R2", "no pid match", {127'b0, hit}, 128'd0);
    wr_ent(0, mk(1'b1, 1'b0, 8'h00, 20'h4_0000, 24'h12_3456, 4'd1, 6'h00, 5'h0, 2'h0, 4'h0, 1'b0));
    lookup(32'h4000_0010, 1'b0, 8'hF1, 8'hF2, 8'hF3, 1'b0, 2'd0);
    check("R2", "zero tid global", {127'b0, hit}, 128'd1);

    // R1: address space and valid
    lookup(32'h4000_0010, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0);
    check("R1", "as mismatch", {127'b0, hit}, 128'd0);
    check("R7", "miss fault low", {127'b0, fault}, 128'd0);
    wr_ent(0, mk(1'b0, 1'b0, 8'h00, 20'h4_0000, 24'h12_3456, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b0));
    lookup(32'h4000_0010, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0);
    check("R1", "invalid entry", {127'b0, hit}, 128'd0);
    check("R7", "miss attrs zero", {116'b0, multi, wimge, xattr, uattr}, 128'd0);

    // R8: multi-hit
    wr_ent(3, mk(1'b1, 1'b1, 8'h00, 20'h8_0000, 24'hAA_0001, 4'd1, 6'h3F, 5'h01, 2'h0, 4'h0, 1'b0));
    wr_ent(5, mk(1'b1, 1'b1, 8'h00, 20'h8_0000, 24'hBB_0002, 4'd1, 6'h3F, 5'h02, 2'h0, 4'h0, 1'b0));
    lookup(32'h8000_0ABC, 1'b1, 8'h0, 8'h0, 8'h0, 1'b1, 2'd0);
    check("R8", "multi flag", {126'b0, hit, multi}, {126'b0, 2'b11});
    check("R8", "lowest index ra", {92'b0, ra}, {92'b0, 36'hAA_0001_ABC});
    wr_ent(3, '0);
    lookup(32'h8000_0ABC, 1'b1, 8'h0, 8'h0, 8'h0, 1'b1, 2'd0);
    check("R8", "single hit", {126'b0, hit, multi}, {126'b0, 2'b10});
    check("R8", "remaining ra", {92'b0, ra}, {92'b0, 36'hBB_0002_ABC});
    wr_ent(5, '0);

    // R9: flash invalidate
    wr_ent(2, mk(1'b1, 1'b0, 8'h00, 20'h2_0000, 24'h00_2000, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b1));
    wr_ent(4, mk(1'b1, 1'b0, 8'h00, 20'h4_4000, 24'h00_4000, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b0));
    wr_ent(6, mk(1'b1, 1'b0, 8'h00, 20'h6_6000, 24'h00_6000, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b0));
    @(negedge clk);
    flash_inv = 1'b1; stg_wr = 1'b1; stg_idx = 4'd6;
    stg_wdata = mk(1'b1, 1'b0, 8'h00, 20'h7_7000, 24'h00_7000, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b0);
    @(negedge clk);
    flash_inv = 1'b0; stg_wr = 1'b0;
    rd_ent(2, rd);
    check("R9", "protected kept", rd, mk(1'b1, 1'b0, 8'h00, 20'h2_0000, 24'h00_2000, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b1));
    rd_ent(4, rd);
    check("R9", "unprotected cleared", rd, mk(1'b0, 1'b0, 8'h00, 20'h4_4000, 24'h00_4000, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b0));
    rd_ent(6, rd);
    check("R9", "write wins", rd, mk(1'b1, 1'b0, 8'h00, 20'h7_7000, 24'h00_7000, 4'd1, 6'h3F, 5'h0, 2'h0, 4'h0, 1'b0));
    lookup(32'h2000_0044, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, 2'd0);
    check("R9", "protected still hits", {127'b0, hit}, 128'd1);
    lookup(32'h4400_0044, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, 2'd0);
    check("R9", "cleared misses", {127'b0, hit}, 128'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule